// File: doc/BRIEF.md
# Spiral-Order Differential Phase Subcarrier Buffer

This block holds one symbol's worth of subcarrier bytes between a host byte stream and a transform engine. A 256 x 8 byte store is indexed by subcarrier, with DC at address 0 and negative frequencies wrapping down from address 255. On the host side, a local counter visits subcarriers in an alternating spiral: DC first, then -1, +1, -2, +2 and so on. The host therefore never supplies an address. On the engine side, each access carries a bin index. That index is sign-extended according to the selected transform size.

A second 256 x 8 store keeps, per subcarrier, the phase of the previous symbol. This makes the buffer a differential phase coder. In transmit mode the host writes a byte holding a 4-bit magnitude and a 4-bit phase. When the engine reads a bin, the phase it receives is either that 4-bit value taken as absolute, or that value added to the stored reference. In receive mode the engine writes an 8-bit measured phase per bin. The buffer stores the difference from the previous symbol, and the host reads these differences back in spiral order, pausing whenever it likes. A one-cycle completion strobe marks the end of each receive write burst and rewinds the host-side counter.

Top module: `spiral_phase_buf`

## Requirements
- R1: The host-side address starts at 0 and steps through 0, -1, +1, -2, +2, ... in 8-bit two's complement (0x00, 0xFF, 0x01, 0xFE, 0x02, ...). The access count n maps to address n/2 for even n and to -(n+1)/2 for odd n.
- R2: The host-side counter returns to address 0 when `rst` is high, when `tx_rst` is high in transmit mode (`xmt`=1), or when `rx_done` is high in receive mode. It advances once per accepted host transmit write, and once per cycle with `rx_vld` high.
- R3: In transmit mode, an accepted host write stores `{tx_mag, tx_phs}` (magnitude in bits 7:4, phase in bits 3:0) at the spiral address. An engine read of that subcarrier returns the magnitude on `eng_mag` in the same cycle.
- R4: In transmit mode, during an engine read, `eng_phs` equals the stored phase when `abs_phase`=1. When `abs_phase`=0 it equals the stored phase plus bits 7:4 of the subcarrier's reference, modulo 16. The reference then becomes `{eng_phs, 4'b0000}`.
- R5: In receive mode, an engine write stores `eng_wr_phs` minus the subcarrier's reference, modulo 256, in the byte store. It also makes `eng_wr_phs` the new reference.
- R6: An engine bin index is mapped to a subcarrier address by sign extension from bit 4, 5, 6 or 7 for `size_code` 0, 1, 2 or 3 (32, 64, 128 or 256 points). Bins at or above half the size land just below address 0.
- R7: In transmit mode, a host write in a cycle with `eng_rd` high is ignored. Nothing is stored and the spiral counter does not advance.
- R8: `rx_vld` is high exactly when receive mode, `rx_oe` high and `eng_wr` low coincide. While it is high, `rx_phs` shows the byte at the current spiral address.
- R9: `rx_done` pulses for exactly one cycle, only in receive mode, in the first cycle with `eng_wr` low after a cycle with `eng_wr` high.
- R10: After reset every reference phase is zero, so the first relative transmit read of a subcarrier returns its stored phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xmt | input | 1 | Mode: 1 transmit, 0 receive |
| size_code | input | 2 | Transform size: 0=32, 1=64, 2=128, 3=256 |
| tx_rst | input | 1 | Rewind host spiral counter (transmit mode) |
| tx_wr | input | 1 | Host transmit byte valid |
| tx_mag | input | 4 | Host transmit magnitude |
| tx_phs | input | 4 | Host transmit phase (22.5-degree steps) |
| abs_phase | input | 1 | 1: phase is absolute, 0: phase is an increment |
| eng_rd | input | 1 | Engine reads a bin (transmit mode) |
| eng_rd_idx | input | 8 | Engine read bin index |
| eng_mag | output | 4 | Magnitude of the bin being read |
| eng_phs | output | 4 | Output phase of the bin being read |
| eng_wr | input | 1 | Engine writes a bin (receive mode) |
| eng_wr_idx | input | 8 | Engine write bin index |
| eng_wr_phs | input | 8 | Measured bin phase (about 1.4-degree steps) |
| rx_oe | input | 1 | Host ready to take a received byte |
| rx_vld | output | 1 | Received byte valid on `rx_phs` |
| rx_phs | output | 8 | Received differential phase |
| rx_done | output | 1 | One-cycle strobe after the last engine write |

## Verification
The bench drives the host-side spiral across all four sizes. The size-32 case is the sharpest, because the upper bins must wrap to 0xF0..0xFF: a wrong sign-extension bit would send those reads to the wrong subcarrier and return wrong magnitudes. It fires host writes in the same cycle as engine reads. A design that lets those writes through, or advances its counter anyway, shifts every later subcarrier by one spiral position. It runs consecutive symbols in relative mode so that a missing or late reference write-back shows up as a wrong accumulated phase. In receive mode it interrupts readout both with `rx_oe` gaps and with engine writes, checking that the completion strobe lasts one cycle and rewinds the counter, and that no differential byte is skipped or repeated.

// File: rtl/scbuf_pkg.sv
package scbuf_pkg;

  localparam int SC_AW  = 8;  // subcarrier address width
  localparam int SC_DW  = 8;  // stored byte / received phase width
  localparam int SC_NW  = 4;  // transmit nibble width
  localparam int SC_SZW = 2;  // transform size code width

  typedef logic [SC_AW-1:0]  sc_addr_t;
  typedef logic [SC_DW-1:0]  sc_byte_t;
  typedef logic [SC_NW-1:0]  sc_nib_t;
  typedef logic [SC_SZW-1:0] sc_size_t;

  // next spiral address: odd step subtracts, even step adds
  function automatic sc_addr_t spiral_next(input sc_addr_t addr, input sc_addr_t step);
    return step[0] ? (addr - step) : (addr + step);
  endfunction

  // sign-extend a transform bin index from the top bit of the selected size
  function automatic sc_addr_t bin_to_addr(input sc_addr_t idx, input sc_size_t code);
    sc_addr_t r;
    logic     sgn;
    int       top;
    top = SC_AW - SC_SZW - 2 + int'(code);
    sgn = 1'b0;
    for (int j = 0; j < SC_AW; j++)
      if (j == top) sgn = idx[j];
    for (int i = 0; i < SC_AW; i++)
      r[i] = (i <= top) ? idx[i] : sgn;
    return r;
  endfunction

  // transmit phase: absolute, or increment on top of the reference's upper nibble
  function automatic sc_nib_t tx_phase(input sc_nib_t inc, input sc_byte_t ref_ph, input logic abs_mode);
    return abs_mode ? inc : sc_nib_t'(inc + ref_ph[SC_DW-1 -: SC_NW]);
  endfunction

  // receive phase: difference from previous symbol, wraps modulo 2^SC_DW
  function automatic sc_byte_t rx_phase_diff(input sc_byte_t cur, input sc_byte_t ref_ph);
    return sc_byte_t'(cur - ref_ph);
  endfunction

endpackage

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int AW        = scbuf_pkg::SC_AW,
  parameter int DW        = scbuf_pkg::SC_DW,
  parameter bit CLEAR_RST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read is asynchronous: value seen in the access cycle is the pre-write content
  assign rdata = mem[addr];

  generate
    if (CLEAR_RST) begin : g_clear
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
          mem[addr] <= wdata;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
      end
    end
  endgenerate

endmodule

// File: rtl/spiral_addr_gen.sv
module spiral_addr_gen
  import scbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     adv,
  output sc_addr_t addr
);
  sc_addr_t step;
  sc_addr_t addr_nx;
  logic     restart;

  assign restart = rst | clr;
  assign addr_nx = spiral_next(addr, step);

  always_ff @(posedge clk) begin
    if (restart) begin
      addr <= '0;
      step <= sc_addr_t'(1);
    end else if (adv) begin
      addr <= addr_nx;
      step <= step + sc_addr_t'(1);
    end
  end

  // spiral invariant: twice the address is step-1 (odd step) or -step (even step)
  AST_SPIRAL_INVARIANT: assert property (@(posedge clk) disable iff (rst)
    step[0] ? ({addr[SC_AW-2:0], 1'b1} == step) : ({addr[SC_AW-2:0], 1'b0} == sc_addr_t'(-step))); // R1

  AST_SPIRAL_REWIND: assert property (@(posedge clk) disable iff (rst)
    clr |=> (addr == '0) && (step == sc_addr_t'(1))); // R2

endmodule

// File: rtl/phase_codec.sv
module phase_codec
  import scbuf_pkg::*;
(
  input  logic     xmt,
  input  sc_size_t size_code,
  input  sc_addr_t bin_idx,
  input  logic     abs_phase,
  input  sc_byte_t buf_rd,
  input  sc_byte_t ref_rd,
  input  sc_byte_t meas_phs,
  output sc_addr_t bin_addr,
  output sc_nib_t  out_mag,
  output sc_nib_t  out_phs,
  output sc_byte_t diff_phs,
  output sc_byte_t ref_wd
);
  localparam int PAD = SC_DW - SC_NW;

  assign bin_addr = bin_to_addr(bin_idx, size_code);
  assign out_mag  = buf_rd[SC_DW-1 -: SC_NW];
  assign out_phs  = tx_phase(buf_rd[SC_NW-1:0], ref_rd, abs_phase);
  assign diff_phs = rx_phase_diff(meas_phs, ref_rd);
  // next reference: produced 4-bit phase in the upper nibble, or the measured phase
  assign ref_wd   = xmt ? {out_phs, {PAD{1'b0}}} : meas_phs;

endmodule

// File: rtl/spiral_phase_buf.sv
module spiral_phase_buf
  import scbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       xmt,
  input  logic [1:0] size_code,
  input  logic       tx_rst,
  input  logic       tx_wr,
  input  logic [3:0] tx_mag,
  input  logic [3:0] tx_phs,
  input  logic       abs_phase,
  input  logic       eng_rd,
  input  logic [7:0] eng_rd_idx,
  output logic [3:0] eng_mag,
  output logic [3:0] eng_phs,
  input  logic       eng_wr,
  input  logic [7:0] eng_wr_idx,
  input  logic [7:0] eng_wr_phs,
  input  logic       rx_oe,
  output logic       rx_vld,
  output logic [7:0] rx_phs,
  output logic       rx_done
);
  // internal events, named for the assertions
  logic     eng_active;   // engine owns the buffer address this cycle
  logic     host_tx_acc;  // host transmit write accepted
  logic     spiral_clr;
  logic     spiral_adv;
  logic     eng_wr_q;

  sc_addr_t host_addr;
  sc_addr_t bin_idx;
  sc_addr_t bin_addr;
  sc_addr_t buf_addr;
  sc_byte_t buf_rd, buf_wd, ref_rd, ref_wd, diff_phs;
  logic     buf_we;

  assign eng_active  = xmt ? eng_rd : eng_wr;
  assign host_tx_acc = xmt & tx_wr & ~eng_rd;
  assign rx_vld      = ~xmt & rx_oe & ~eng_wr;

  always_ff @(posedge clk) begin
    if (rst) eng_wr_q <= 1'b0;
    else     eng_wr_q <= eng_wr;
  end

  assign rx_done    = ~xmt & eng_wr_q & ~eng_wr;
  assign spiral_clr = xmt ? tx_rst : rx_done;
  assign spiral_adv = xmt ? host_tx_acc : rx_vld;

  spiral_addr_gen u_spiral (
    .clk  (clk),
    .rst  (rst),
    .clr  (spiral_clr),
    .adv  (spiral_adv),
    .addr (host_addr)
  );

  assign bin_idx = xmt ? eng_rd_idx : eng_wr_idx;

  phase_codec u_codec (
    .xmt       (xmt),
    .size_code (size_code),
    .bin_idx   (bin_idx),
    .abs_phase (abs_phase),
    .buf_rd    (buf_rd),
    .ref_rd    (ref_rd),
    .meas_phs  (eng_wr_phs),
    .bin_addr  (bin_addr),
    .out_mag   (eng_mag),
    .out_phs   (eng_phs),
    .diff_phs  (diff_phs),
    .ref_wd    (ref_wd)
  );

  assign buf_addr = eng_active ? bin_addr : host_addr;
  assign buf_we   = xmt ? host_tx_acc : eng_wr;
  assign buf_wd   = xmt ? {tx_mag, tx_phs} : diff_phs;

  sc_ram #(.AW(SC_AW), .DW(SC_DW), .CLEAR_RST(1'b0)) u_symbuf (
    .clk   (clk),
    .rst   (rst),
    .we    (buf_we),
    .addr  (buf_addr),
    .wdata (buf_wd),
    .rdata (buf_rd)
  );

  sc_ram #(.AW(SC_AW), .DW(SC_DW), .CLEAR_RST(1'b1)) u_refbuf (
    .clk   (clk),
    .rst   (rst),
    .we    (eng_active),
    .addr  (bin_addr),
    .wdata (ref_wd),
    .rdata (ref_rd)
  );

  assign rx_phs = buf_rd;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done); // R9

  AST_DONE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> $past(eng_wr)); // R9

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (xmt && eng_rd && !tx_rst) |=> $stable(host_addr)); // R7

  AST_RX_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!xmt && !rx_vld && !rx_done) |=> $stable(host_addr)); // R8

endmodule

// File: tb/spiral_phase_buf_tb.sv
`timescale 1ns/100ps
module spiral_phase_buf_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       xmt;
  logic [1:0] size_code;
  logic       tx_rst, tx_wr, abs_phase, eng_rd, eng_wr, rx_oe;
  logic [3:0] tx_mag, tx_phs;
  logic [7:0] eng_rd_idx, eng_wr_idx, eng_wr_phs;
  logic [3:0] eng_mag, eng_phs;
  logic       rx_vld, rx_done;
  logic [7:0] rx_phs;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model state
  logic [7:0] m_buf [256];
  logic [7:0] m_ref [256];
  int         m_n;
  logic       m_wr_q;

  always #2.5 clk = ~clk;

  spiral_phase_buf dut_i (
    .clk(clk), .rst(rst), .xmt(xmt), .size_code(size_code),
    .tx_rst(tx_rst), .tx_wr(tx_wr), .tx_mag(tx_mag), .tx_phs(tx_phs),
    .abs_phase(abs_phase), .eng_rd(eng_rd), .eng_rd_idx(eng_rd_idx),
    .eng_mag(eng_mag), .eng_phs(eng_phs), .eng_wr(eng_wr),
    .eng_wr_idx(eng_wr_idx), .eng_wr_phs(eng_wr_phs), .rx_oe(rx_oe),
    .rx_vld(rx_vld), .rx_phs(rx_phs), .rx_done(rx_done)
  );

  // spiral position of the n-th host access, counted from the rewind
  function automatic logic [7:0] spiral_at(input int n);
    int v;
    v = (n % 2 == 1) ? -((n + 1) / 2) : (n / 2);
    return v[7:0];
  endfunction

  // bins in the upper half of the transform are negative frequencies
  function automatic logic [7:0] bin_map(input int k, input int sz);
    int npts;
    int kk;
    npts = 32 << sz;
    kk = k % npts;
    if (kk >= npts / 2) kk = kk - npts + 256;
    return kk[7:0];
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_rst = 0; tx_wr = 0; eng_rd = 0; eng_wr = 0; rx_oe = 0;
    tx_mag = 0; tx_phs = 0; eng_rd_idx = 0; eng_wr_idx = 0; eng_wr_phs = 0;
  endtask

  // inputs are set; check outputs mid-cycle, advance the model, go to next negedge
  task automatic tick();
    logic [7:0] a;
    logic [3:0] ep;
    logic       ev, ed;
    #1;
    if (xmt) begin
      chk({7'd0, rx_vld}, 8'd0, "R8 rx_vld in transmit mode");
      chk({7'd0, rx_done}, 8'd0, "R9 rx_done in transmit mode");
      if (eng_rd) begin
        a  = bin_map(int'(eng_rd_idx), int'(size_code));
        ep = abs_phase ? m_buf[a][3:0] : 4'(m_buf[a][3:0] + m_ref[a][7:4]);
        chk({4'd0, eng_mag}, {4'd0, m_buf[a][7:4]}, "R3/R6/R7 eng_mag");
        chk({4'd0, eng_phs}, {4'd0, ep}, "R4/R10 eng_phs");
        m_ref[a] = {ep, 4'd0};
      end
      if (tx_wr && !eng_rd) m_buf[spiral_at(m_n)] = {tx_mag, tx_phs};
      if (tx_rst) m_n = 0;
      else if (tx_wr && !eng_rd) m_n++;
    end else begin
      ev = rx_oe && !eng_wr;
      ed = m_wr_q && !eng_wr;
      chk({7'd0, rx_vld}, {7'd0, ev}, "R8 rx_vld");
      chk({7'd0, rx_done}, {7'd0, ed}, "R9 rx_done");
      if (ev) chk(rx_phs, m_buf[spiral_at(m_n)], "R1/R2/R5/R8 rx_phs");
      if (eng_wr) begin
        a = bin_map(int'(eng_wr_idx), int'(size_code));
        m_buf[a] = 8'(eng_wr_phs - m_ref[a]);
        m_ref[a] = eng_wr_phs;
      end
      if (ed) m_n = 0;
      else if (ev) m_n++;
    end
    m_wr_q = eng_wr;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int npts, got;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) m_ref[i] = 8'd0;
    m_n = 0; m_wr_q = 0;
    idle_inputs();
    rst = 1; xmt = 0; size_code = 3; abs_phase = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    // reset state, receive mode, nothing requested
    tick();
    tick();

    // fill all 256 subcarriers in spiral order (R1, R2, R3)
    xmt = 1; size_code = 3;
    tx_rst = 1; tick();
    for (int i = 0; i < 256; i++) begin
      tx_wr = 1; tx_mag = 4'($urandom); tx_phs = 4'($urandom); tick();
    end

    // R10: first relative reads return stored phase unchanged
    abs_phase = 0;
    for (int k = 0; k < 256; k++) begin
      eng_rd = 1; eng_rd_idx = 8'(k); tick();
    end

    // directed R7: a write colliding with an engine read is dropped
    size_code = 0;
    tx_rst = 1; tick();
    tx_wr = 1; tx_mag = 4'hA; tx_phs = 4'h3; tick();
    tx_wr = 1; tx_mag = 4'h5; tx_phs = 4'hC; eng_rd = 1; eng_rd_idx = 8'd5; tick();
    tx_wr = 1; tx_mag = 4'h7; tx_phs = 4'h1; tick();
    eng_rd = 1; eng_rd_idx = 8'd0;  tick();
    eng_rd = 1; eng_rd_idx = 8'd31; tick();
    eng_rd = 1; eng_rd_idx = 8'd5;  tick();

    // random transmit symbols over all sizes (R4, R6, R7)
    for (int s = 0; s < 8; s++) begin
      size_code = 2'(s % 4);
      npts = 32 << size_code;
      tx_rst = 1; tick();
      got = 0;
      while (got < npts) begin
        tx_wr = 1; tx_mag = 4'($urandom); tx_phs = 4'($urandom);
        eng_rd = ($urandom % 4 == 0);
        eng_rd_idx = 8'($urandom % npts);
        if (!eng_rd) got++;
        tick();
      end
      abs_phase = ($urandom % 3 == 0);
      for (int k = 0; k < npts; k++) begin
        eng_rd = 1; eng_rd_idx = 8'(k); tick();
      end
      abs_phase = 0;
    end

    // receive symbols: differential decode, paced readout (R5, R8, R9)
    xmt = 0;
    for (int s = 0; s < 8; s++) begin
      size_code = 2'((s + 1) % 4);
      npts = 32 << size_code;
      for (int k = 0; k < npts; k++) begin
        eng_wr = 1; eng_wr_idx = 8'(k); eng_wr_phs = 8'($urandom); tick();
      end
      tick(); // rx_done cycle, rewinds spiral (R2)
      got = 0;
      while (got < npts) begin
        rx_oe = ($urandom % 4 != 0);
        if (rx_oe) got++;
        tick();
      end
    end

    // readout interrupted by an engine write: no valid, then a strobe and rewind
    size_code = 0;
    for (int k = 0; k < 32; k++) begin
      eng_wr = 1; eng_wr_idx = 8'(k); eng_wr_phs = 8'($urandom); tick();
    end
    tick();
    for (int i = 0; i < 5; i++) begin rx_oe = 1; tick(); end
    rx_oe = 1; eng_wr = 1; eng_wr_idx = 8'd17; eng_wr_phs = 8'h80; tick();
    for (int i = 0; i < 6; i++) begin rx_oe = 1; tick(); end

    // engine writes in transmit mode produce no strobe (R9)
    xmt = 1;
    eng_wr = 1; tick();
    tick();

    finish_run();
  end

endmodule